// File: doc/BRIEF.md
# Halting Debug Control Register Bank

This block is the register bank a debugger uses to stop, step and inspect a processor core. A word-wide access port reaches six registers at fixed offsets. It holds the halt, step and interrupt-mask requests sent to the core. It collects sticky status events from the core and clears them when the debugger reads them. It also runs a request/acknowledge handshake that moves one core register through a shared data register.

A write to the halting control register changes nothing unless its upper half carries a 16-bit key. A write to the select register starts a transfer, and that transfer stays pending until the core acknowledges it. The security-state bit accepts a new value only when the same write holds its companion key bit at zero. Two authentication override bits decide whether the invasive and non-invasive debug enables come from external inputs or from internal register bits.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x10 control/status, 0x14 select, 0x18 data, 0x1C catch/trace, 0x24 authentication, 0x28 secure. Any other offset reads as zero, and a write to it has no effect. The select register reads as zero.
- R2: A write to 0x10 whose bits 31:16 are not 0xA05F leaves every control bit unchanged.
- R3: A keyed write to 0x10 loads bit 0 into `dbg_en`, bit 1 into `halt_req`, bit 2 into `step_req` and bit 3 into `mask_ints`. A pulse on `ext_restart` clears `halt_req`, and it takes priority over a write in the same cycle.
- R4: A read of 0x10 shows the control bits in 3:0. It shows transfer-ready in bit 16, core halted in bit 17, sleeping in bit 18 and lockup in bit 19, each as a live level.
- R5: Bit 24 (retired), bit 25 (core reset) and bit 26 (restart processed) of 0x10 are set by pulses on `core_retired`, `core_reset` and `core_restarted`. Each stays set until a read of 0x10 clears it. An event that arrives in the same cycle as the read keeps its bit set.
- R6: When no transfer is pending, a write to 0x14 starts a transfer. It raises `xfer_req`, takes `xfer_sel` from bits 6:0 and `xfer_wr` from bit 16 (1 = write to core), and clears ready. While a transfer is pending, a write to 0x14 is ignored.
- R7: `xfer_req` stays high until `xfer_ack`, and then ready sets. On acknowledge, a read transfer loads `xfer_rdata` into the data register; a write transfer leaves it unchanged. `xfer_wdata` always shows the data register.
- R8: In 0x1C, bit 24 (`trace_en`), bit 10 (`catch_hardfault`) and bit 0 (`catch_reset`) can be read and written. All other bits of 0x1C read as zero.
- R9: In 0x28, bits 1:0 are always written and drive `bank_sel`/`bank_sel_en`. Bit 16 (`sec_state`) changes only when bit 17 of the same write is 0, and bit 17 reads as zero.
- R10: In 0x24, `invasive_en` comes from bit 1 when bit 0 is set and from `ext_inv_en` otherwise. `noninvasive_en` comes from bit 3 when bit 2 is set and from `ext_noninv_en` otherwise.
- R11: After reset, every control output is 0, no transfer is pending, and a read of 0x10 returns 0x00010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Byte offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| core_halted | input | 1 | Core is in debug state |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is locked up |
| core_retired | input | 1 | Pulse: instructions retired |
| core_reset | input | 1 | Pulse: core was reset |
| core_restarted | input | 1 | Pulse: core acted on a halt clear |
| ext_restart | input | 1 | Pulse: external restart request |
| dbg_en | output | 1 | Halting debug enable |
| halt_req | output | 1 | Halt request |
| step_req | output | 1 | Single-step enable |
| mask_ints | output | 1 | Interrupt mask request |
| xfer_req | output | 1 | Core register transfer pending |
| xfer_wr | output | 1 | Transfer direction, 1 = write to core |
| xfer_sel | output | 7 | Core register number |
| xfer_wdata | output | 32 | Data for write transfers |
| xfer_ack | input | 1 | Core acknowledges transfer |
| xfer_rdata | input | 32 | Core data for read transfers |
| trace_en | output | 1 | Global trace enable |
| catch_hardfault | output | 1 | Halt on hard fault |
| catch_reset | output | 1 | Halt on reset vector |
| ext_inv_en | input | 1 | External invasive debug enable |
| ext_noninv_en | input | 1 | External non-invasive debug enable |
| invasive_en | output | 1 | Effective invasive debug enable |
| noninvasive_en | output | 1 | Effective non-invasive debug enable |
| sec_state | output | 1 | Security state bit |
| bank_sel_en | output | 1 | Banked-register select enable |
| bank_sel | output | 1 | Banked-register select |

## Verification
The assertions check on every cycle that:
- a keyless control write changes nothing;
- an external restart always drops the halt request;
- a pending transfer holds until it is acknowledged, and an idle select write always raises one;
- a core reset pulse always sets its sticky bit;
- a write that carries the companion key bit never moves the security state.

Only the bench scenarios can show the rest: the exact read-view bit positions, clear-on-read, read data captured on acknowledge, a select write ignored while busy, and the authentication multiplexing against the external inputs.

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl #(
  parameter int AW = 8,
  parameter logic [15:0] KEY = 16'hA05F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [31:0]   acc_wdata,
  output logic [31:0]   acc_rdata,
  input  logic          core_halted,
  input  logic          core_sleeping,
  input  logic          core_lockup,
  input  logic          core_retired,
  input  logic          core_reset,
  input  logic          core_restarted,
  input  logic          ext_restart,
  output logic          dbg_en,
  output logic          halt_req,
  output logic          step_req,
  output logic          mask_ints,
  output logic          xfer_req,
  output logic          xfer_wr,
  output logic [6:0]    xfer_sel,
  output logic [31:0]   xfer_wdata,
  input  logic          xfer_ack,
  input  logic [31:0]   xfer_rdata,
  output logic          trace_en,
  output logic          catch_hardfault,
  output logic          catch_reset,
  input  logic          ext_inv_en,
  input  logic          ext_noninv_en,
  output logic          invasive_en,
  output logic          noninvasive_en,
  output logic          sec_state,
  output logic          bank_sel_en,
  output logic          bank_sel
);
  localparam logic [AW-1:0] OFF_CTRL = AW'(8'h10);
  localparam logic [AW-1:0] OFF_SEL  = AW'(8'h14);
  localparam logic [AW-1:0] OFF_DATA = AW'(8'h18);
  localparam logic [AW-1:0] OFF_CATC = AW'(8'h1C);
  localparam logic [AW-1:0] OFF_AUTH = AW'(8'h24);
  localparam logic [AW-1:0] OFF_SEC  = AW'(8'h28);

  logic wr, rd, key_ok, ready, done;
  logic ret_st, rst_st, rsr_st;
  logic [31:0] data_q;
  logic [3:0]  auth_q;

  assign wr     = acc_valid & acc_write;
  assign rd     = acc_valid & ~acc_write;
  assign key_ok = acc_wdata[31:16] == KEY;
  assign ready  = ~xfer_req;
  assign done   = xfer_req & xfer_ack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {mask_ints, step_req, halt_req, dbg_en} <= '0;
    else begin
      if (wr && acc_addr == OFF_CTRL && key_ok)
        {mask_ints, step_req, halt_req, dbg_en} <= acc_wdata[3:0];
      if (ext_restart) halt_req <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ret_st, rst_st, rsr_st} <= '0;
    else begin
      ret_st <= core_retired   | (ret_st & ~(rd && acc_addr == OFF_CTRL));
      rst_st <= core_reset     | (rst_st & ~(rd && acc_addr == OFF_CTRL));
      rsr_st <= core_restarted | (rsr_st & ~(rd && acc_addr == OFF_CTRL));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xfer_req <= 1'b0;
      xfer_wr  <= 1'b0;
      xfer_sel <= '0;
      data_q   <= '0;
    end else begin
      if (wr && acc_addr == OFF_SEL && ready) begin
        xfer_req <= 1'b1;
        xfer_wr  <= acc_wdata[16];
        xfer_sel <= acc_wdata[6:0];
      end else if (done) xfer_req <= 1'b0;
      if (done && !xfer_wr) data_q <= xfer_rdata;
      else if (wr && acc_addr == OFF_DATA) data_q <= acc_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {trace_en, catch_hardfault, catch_reset} <= '0;
      auth_q <= '0;
      {sec_state, bank_sel, bank_sel_en} <= '0;
    end else if (wr) begin
      if (acc_addr == OFF_CATC)
        {trace_en, catch_hardfault, catch_reset} <= {acc_wdata[24], acc_wdata[10], acc_wdata[0]};
      if (acc_addr == OFF_AUTH) auth_q <= acc_wdata[3:0];
      if (acc_addr == OFF_SEC) begin
        {bank_sel, bank_sel_en} <= acc_wdata[1:0];
        if (!acc_wdata[17]) sec_state <= acc_wdata[16];
      end
    end

  assign xfer_wdata     = data_q;
  assign invasive_en    = auth_q[0] ? auth_q[1] : ext_inv_en;
  assign noninvasive_en = auth_q[2] ? auth_q[3] : ext_noninv_en;

  always_comb begin
    acc_rdata = '0;
    case (acc_addr)
      OFF_CTRL: acc_rdata = {5'b0, rsr_st, rst_st, ret_st, 4'b0, core_lockup, core_sleeping,
                             core_halted, ready, 12'b0, mask_ints, step_req, halt_req, dbg_en};
      OFF_DATA: acc_rdata = data_q;
      OFF_CATC: acc_rdata = {7'b0, trace_en, 13'b0, catch_hardfault, 9'b0, catch_reset};
      OFF_AUTH: acc_rdata = {28'b0, auth_q};
      OFF_SEC:  acc_rdata = {15'b0, sec_state, 14'b0, bank_sel, bank_sel_en};
      default:  acc_rdata = '0;
    endcase
  end
endmodule

module dbg_halt_ctrl_chk #(
  parameter int AW = 8,
  parameter logic [15:0] KEY = 16'hA05F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [AW-1:0] acc_addr,
  input logic [15:0]   wkey,
  input logic          cdskey,
  input logic          ext_restart,
  input logic [3:0]    ctrl,
  input logic          halt_req,
  input logic          xfer_req,
  input logic          xfer_ack,
  input logic          core_reset,
  input logic          rst_st,
  input logic          sec_state
);
  logic wr;
  assign wr = acc_valid & acc_write;

  // R2
  no_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_addr == AW'(8'h10) && wkey != KEY && !ext_restart) |=> $stable(ctrl));

  // R3
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_restart |=> !halt_req);

  // R6
  start_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_addr == AW'(8'h14) && !xfer_req) |=> xfer_req);

  // R7
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> xfer_req);

  // R5
  reset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> rst_st);

  // R9
  cds_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_addr == AW'(8'h28) && cdskey) |=> $stable(sec_state));
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.AW(AW), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .wkey(acc_wdata[31:16]), .cdskey(acc_wdata[17]),
  .ext_restart(ext_restart), .ctrl({mask_ints, step_req, halt_req, dbg_en}),
  .halt_req(halt_req), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
  .core_reset(core_reset), .rst_st(rst_st), .sec_state(sec_state)
);

// File: tb/sim_dbg_halt_ctrl.sv
module sim_dbg_halt_ctrl;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic core_halted = 0, core_sleeping = 0, core_lockup = 0;
  logic core_retired = 0, core_reset = 0, core_restarted = 0, ext_restart = 0;
  logic dbg_en, halt_req, step_req, mask_ints;
  logic xfer_req, xfer_wr, xfer_ack = 0;
  logic [6:0] xfer_sel;
  logic [31:0] xfer_wdata, xfer_rdata = '0;
  logic trace_en, catch_hardfault, catch_reset;
  logic ext_inv_en = 0, ext_noninv_en = 0, invasive_en, noninvasive_en;
  logic sec_state, bank_sel_en, bank_sel;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  dbg_halt_ctrl #(.AW(AW)) u0 (.*);

  // {offset, write data, expected readback at same offset}
  localparam logic [71:0] VEC [12] = '{
    {8'h10, 32'h0000_0003, 32'h0001_0000},  // R2 no key
    {8'h10, 32'hA05F_0003, 32'h0001_0003},  // R3 keyed
    {8'h10, 32'hA05E_000F, 32'h0001_0003},  // R2 wrong key
    {8'h1C, 32'hFFFF_FFFF, 32'h0100_0401},  // R8
    {8'h1C, 32'h0100_0000, 32'h0100_0000},  // R8
    {8'h24, 32'h0000_000F, 32'h0000_000F},  // R10
    {8'h28, 32'h0003_0003, 32'h0000_0003},  // R9 key bit set
    {8'h28, 32'h0001_0002, 32'h0001_0002},  // R9
    {8'h28, 32'h0002_0000, 32'h0001_0000},  // R9
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},  // R1 reserved
    {8'h18, 32'h1234_5678, 32'h1234_5678},  // R1 data
    {8'h10, 32'hA05F_0000, 32'h0001_0000}   // R3 clear
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_valid = 0;
  endtask

  initial begin
    #(20 * 20000);
    errors++; checks++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 ctrl outputs", {28'b0, dbg_en, halt_req, step_req, mask_ints}, 32'h0);
    chk("R11 misc outputs", {26'b0, xfer_req, trace_en, catch_hardfault, catch_reset, sec_state, bank_sel}, 32'h0);
    bus_rd(8'h10, rv); chk("R11 status", rv, 32'h0001_0000);

    for (int i = 0; i < 12; i++) begin
      bus_wr(VEC[i][71:64], VEC[i][63:32]);
      bus_rd(VEC[i][71:64], rv);
      chk($sformatf("R1/R2/R3/R8/R9/R10 vector %0d", i), rv, VEC[i][31:0]);
    end
    chk("R8 trace_en", {31'b0, trace_en}, 32'h1);
    chk("R8 catch_hardfault", {31'b0, catch_hardfault}, 32'h0);
    chk("R9 sec_state", {31'b0, sec_state}, 32'h1);
    bus_rd(8'h14, rv); chk("R1 select reads zero", rv, 32'h0);

    // R6 read transfer start
    bus_wr(8'h14, 32'h0000_0005);
    chk("R6 req/wr/sel", {23'b0, xfer_req, xfer_wr, xfer_sel}, {23'b0, 1'b1, 1'b0, 7'd5});
    bus_rd(8'h10, rv); chk("R6 ready low", rv, 32'h0000_0000);
    repeat (2) @(negedge clk);
    chk("R7 req held", {31'b0, xfer_req}, 32'h1);
    xfer_ack = 1; xfer_rdata = 32'hCAFE_0001;
    @(negedge clk); xfer_ack = 0;
    chk("R7 req dropped", {31'b0, xfer_req}, 32'h0);
    bus_rd(8'h18, rv); chk("R7 read captured", rv, 32'hCAFE_0001);
    bus_rd(8'h10, rv); chk("R7 ready high", rv, 32'h0001_0000);

    // R6/R7 write transfer, select write while busy ignored
    bus_wr(8'h18, 32'h0000_DEAD);
    bus_wr(8'h14, 32'h0001_0003);
    chk("R6 write dir sel", {24'b0, xfer_wr, xfer_sel}, {24'b0, 1'b1, 7'd3});
    chk("R7 wdata", xfer_wdata, 32'h0000_DEAD);
    bus_wr(8'h14, 32'h0000_0007);
    chk("R6 busy ignored", {24'b0, xfer_wr, xfer_sel}, {24'b0, 1'b1, 7'd3});
    xfer_ack = 1; xfer_rdata = 32'h1111_1111;
    @(negedge clk); xfer_ack = 0;
    bus_rd(8'h18, rv); chk("R7 write keeps data", rv, 32'h0000_DEAD);

    // R5 sticky events
    @(negedge clk) core_retired = 1; @(negedge clk) core_retired = 0;
    bus_rd(8'h10, rv); chk("R5 retired set", rv, 32'h0101_0000);
    bus_rd(8'h10, rv); chk("R5 retired cleared", rv, 32'h0001_0000);
    @(negedge clk) core_reset = 1; @(negedge clk) core_reset = 0;
    repeat (3) @(negedge clk);
    bus_rd(8'h10, rv); chk("R5 reset sticky", rv, 32'h0201_0000);
    bus_rd(8'h10, rv); chk("R5 reset cleared", rv, 32'h0001_0000);
    @(negedge clk) core_restarted = 1; @(negedge clk) core_restarted = 0;
    bus_rd(8'h10, rv); chk("R5 restart set", rv, 32'h0401_0000);
    // R5 event in same cycle as read stays set
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = 8'h10; core_retired = 1;
    @(negedge clk);
    acc_valid = 0; core_retired = 0;
    bus_rd(8'h10, rv); chk("R5 event beats read clear", rv, 32'h0101_0000);

    // R4 live levels
    core_halted = 1; core_sleeping = 1; core_lockup = 1;
    bus_rd(8'h10, rv); chk("R4 levels", rv, 32'h000F_0000);
    core_halted = 0; core_sleeping = 0; core_lockup = 0;

    // R3 external restart
    bus_wr(8'h10, 32'hA05F_0003);
    chk("R3 halt set", {30'b0, halt_req, dbg_en}, 32'h3);
    @(negedge clk) ext_restart = 1; @(negedge clk) ext_restart = 0;
    chk("R3 restart clears halt", {30'b0, halt_req, dbg_en}, 32'h1);

    // R10 authentication select
    bus_wr(8'h24, 32'h0);
    ext_inv_en = 1; ext_noninv_en = 1;
    #1 chk("R10 external", {30'b0, invasive_en, noninvasive_en}, 32'h3);
    bus_wr(8'h24, 32'h5);
    chk("R10 internal zero", {30'b0, invasive_en, noninvasive_en}, 32'h0);
    bus_wr(8'h24, 32'h3);
    ext_noninv_en = 0;
    #1 chk("R10 mixed", {30'b0, invasive_en, noninvasive_en}, 32'h2);
    bus_wr(8'h24, 32'hC);
    ext_inv_en = 0;
    #1 chk("R10 internal noninv", {30'b0, invasive_en, noninvasive_en}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule